// File: doc/BRIEF.md
# ECC Error Status and Capture

This block gathers ECC error reports from two protected memories, a RAM and a flash array. Each memory signals a single-bit correction or a non-correctable error as a one-cycle pulse. With the pulse come that memory's faulting address, attribute and data buses. Four enable bits in a control register decide which of the four event kinds are reported. A reported event sets a sticky status flag and loads the capture registers of its memory. Any flag that is set while its enable is set raises a single interrupt request.

Software uses a small word-addressed register bus. It programs the enables, reads and clears the flags, and reads the captured address, attributes and data of the last recorded fault of each memory. Only one event is recorded per cycle. When several reported events coincide, a fixed priority chooses which one sets its flag and loads its capture registers.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the enables, all four flags, all six capture registers and `irq` are zero.
- R2: The status register at word 1 holds RAM single-bit at bit 2, flash single-bit at bit 3, RAM non-correctable at bit 6 and flash non-correctable at bit 7, with all other bits reading zero. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R3: A single-bit correction pulse sets its flag only when its memory's single-bit enable is set: control bit 0 for RAM, bit 1 for flash.
- R4: A non-correctable pulse sets its flag only when its memory's non-correctable enable is set: control bit 2 for RAM, bit 3 for flash.
- R5: When a RAM event is recorded, `ram_addr`, `ram_attr` and `ram_data` are loaded into the RAM capture registers at words 2, 3 and 4. When a flash event is recorded, the flash buses are loaded into words 5, 6 and 7. Captured values read back zero-extended.
- R6: Among the enabled events of one cycle, only the highest-priority one is recorded. The priority order is RAM single-bit, flash single-bit, RAM non-correctable, flash non-correctable. The other events neither set a flag nor load capture registers.
- R7: If a recorded event and a write of 1 to the same flag happen in one cycle, the flag ends up set.
- R8: `irq` is high exactly when some flag and its own enable are both set. It falls in the cycle that follows the clock edge at which the last such flag is cleared or its enable is removed.
- R9: A capture register changes only at an edge where an event of its memory is recorded.
- R10: The control register at word 0 is read/write in bits 3:0, and all its other bits read zero. Reads are combinational from `bus_addr`, and writes take effect at the clock edge where `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_sbc_evt | input | 1 | RAM single-bit correction pulse |
| ram_nce_evt | input | 1 | RAM non-correctable error pulse |
| ram_addr | input | ADDR_W | RAM faulting address |
| ram_attr | input | ATTR_W | RAM access attributes |
| ram_data | input | DATA_W | RAM faulting data |
| fl_sbc_evt | input | 1 | Flash single-bit correction pulse |
| fl_nce_evt | input | 1 | Flash non-correctable error pulse |
| fl_addr | input | ADDR_W | Flash faulting address |
| fl_attr | input | ATTR_W | Flash access attributes |
| fl_data | input | DATA_W | Flash faulting data |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data |
| irq | output | 1 | Combined ECC interrupt request |

## Verification
Flags, enables and capture registers are due at the first clock edge after the event pulse or bus write that causes them. Register reads and `irq` follow that state with no further delay. The bench therefore applies each stimulus just after an edge and updates its own model at the next edge. One time step after that edge, it compares `irq` and then walks `bus_addr` through all eight words with the bus idle, checking every read without advancing the clock. Directed cases cover coincident events, a clear that coincides with an event, and the fall of `irq`. They sit between constrained random cycles that use the same sampling point.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_sbc_evt,
  input  logic              ram_nce_evt,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic              fl_sbc_evt,
  input  logic              fl_nce_evt,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [ATTR_W-1:0] fl_attr,
  input  logic [DATA_W-1:0] fl_data,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1;
  localparam logic [2:0] A_RADR = 3'd2, A_RATR = 3'd3, A_RDAT = 3'd4;
  localparam logic [2:0] A_FADR = 3'd5, A_FATR = 3'd6, A_FDAT = 3'd7;

  logic [3:0]        en_q, flag_q;
  logic [ADDR_W-1:0] ram_addr_q, fl_addr_q;
  logic [ATTR_W-1:0] ram_attr_q, fl_attr_q;
  logic [DATA_W-1:0] ram_data_q, fl_data_q;

  // index order is priority order: 0 highest
  wire [3:0] evt  = {fl_nce_evt, ram_nce_evt, fl_sbc_evt, ram_sbc_evt};
  wire [3:0] live = evt & en_q;
  wire [3:0] pick = live & (~live + 4'd1);
  wire ram_rec = pick[0] | pick[2];
  wire fl_rec  = pick[1] | pick[3];

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire stat_wr = bus_wr && (bus_addr == A_STAT);
  wire [3:0] w1c = stat_wr ? {bus_wdata[7], bus_wdata[6], bus_wdata[3], bus_wdata[2]} : 4'd0;
  wire [7:0] stat_view = {flag_q[3], flag_q[2], 2'b00, flag_q[1], flag_q[0], 2'b00};
  wire unused_wdata = ^{bus_wdata[BUS_W-1:8], bus_wdata[5:4]};

  assign irq = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata[3:0];
      flag_q <= (flag_q & ~w1c) | pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr_q <= '0;
      ram_attr_q <= '0;
      ram_data_q <= '0;
    end else if (ram_rec) begin
      ram_addr_q <= ram_addr;
      ram_attr_q <= ram_attr;
      ram_data_q <= ram_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_addr_q <= '0;
      fl_attr_q <= '0;
      fl_data_q <= '0;
    end else if (fl_rec) begin
      fl_addr_q <= fl_addr;
      fl_attr_q <= fl_attr;
      fl_data_q <= fl_data;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = BUS_W'(en_q);
      A_STAT:  bus_rdata = BUS_W'(stat_view);
      A_RADR:  bus_rdata = BUS_W'(ram_addr_q);
      A_RATR:  bus_rdata = BUS_W'(ram_attr_q);
      A_RDAT:  bus_rdata = BUS_W'(ram_data_q);
      A_FADR:  bus_rdata = BUS_W'(fl_addr_q);
      A_FATR:  bus_rdata = BUS_W'(fl_attr_q);
      default: bus_rdata = BUS_W'(fl_data_q);
    endcase
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    evt,
  input logic [3:0]    en,
  input logic [3:0]    flag,
  input logic [3:0]    w1c,
  input logic          irq,
  input logic [AW-1:0] ram_addr_q,
  input logic [AW-1:0] fl_addr_q
);
  // R3
  flag_needs_enabled_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag)) & ~$past(evt & en)) == 4'd0);

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(w1c) & ~$past(evt & en) & flag) == 4'd0);

  // R6
  one_record_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag & ~$past(flag)) <= 1);

  // R7
  top_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt[0] & en[0]) |-> flag[0]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & en) == 4'd0) |-> !irq);

  // R9
  ram_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(((evt & en) & 4'b0101) == 4'd0) |-> $stable(ram_addr_q));

  // R9
  fl_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(((evt & en) & 4'b1010) == 4'd0) |-> $stable(fl_addr_q));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt(evt), .en(en_q), .flag(flag_q),
  .w1c(w1c), .irq(irq), .ram_addr_q(ram_addr_q), .fl_addr_q(fl_addr_q)
);

// File: tb/ecc_err_capture_tb.sv
`timescale 1ns/1ps
module ecc_err_capture_tb_top;
  logic clk = 0, rst_n = 0;
  logic ram_sbc_evt, ram_nce_evt, fl_sbc_evt, fl_nce_evt, bus_wr, irq;
  logic [31:0] ram_addr, ram_data, fl_addr, fl_data, bus_wdata, bus_rdata;
  logic [7:0] ram_attr, fl_attr;
  logic [2:0] bus_addr;
  int checks = 0, errors = 0;

  logic [3:0]  m_en, m_flag;
  logic [31:0] m_cap [0:5];

  always #4 clk = ~clk;

  ecc_err_capture dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int k);
    if (k == 0) return {28'd0, m_en};
    if (k == 1) return {24'd0, m_flag[3], m_flag[2], 2'b00, m_flag[1], m_flag[0], 2'b00};
    return m_cap[k-2];
  endfunction

  task automatic idle();
    {ram_sbc_evt, ram_nce_evt, fl_sbc_evt, fl_nce_evt, bus_wr} = '0;
    bus_addr = 3'd0; bus_wdata = '0;
  endtask

  task automatic verify_all(string tag);
    chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, |(m_flag & m_en)});
    for (int k = 0; k < 8; k++) begin
      bus_addr = 3'(k); #0.5;
      chk(k == 0 ? {tag, " R10 ctrl"} : k == 1 ? {tag, " R2 status"} : {tag, " R5 capture"},
          bus_rdata, exp_read(k));
    end
    bus_addr = 3'd0;
  endtask

  // inputs are already driven; model the edge, then check
  task automatic step(string tag);
    logic [3:0] ev, live, pick, w;
    ev   = {fl_nce_evt, ram_nce_evt, fl_sbc_evt, ram_sbc_evt};
    live = ev & m_en;
    pick = live & (~live + 4'd1);
    w    = (bus_wr && bus_addr == 3'd1) ? {bus_wdata[7], bus_wdata[6], bus_wdata[3], bus_wdata[2]} : 4'd0;
    @(posedge clk); #1;
    if (pick[0] | pick[2]) begin
      m_cap[0] = ram_addr; m_cap[1] = {24'd0, ram_attr}; m_cap[2] = ram_data;
    end
    if (pick[1] | pick[3]) begin
      m_cap[3] = fl_addr; m_cap[4] = {24'd0, fl_attr}; m_cap[5] = fl_data;
    end
    m_flag = (m_flag & ~w) | pick;
    if (bus_wr && bus_addr == 3'd0) m_en = bus_wdata[3:0];
    idle();
    verify_all(tag);
  endtask

  task automatic set_buses();
    ram_addr = $urandom; ram_attr = 8'($urandom); ram_data = $urandom;
    fl_addr  = $urandom; fl_attr  = 8'($urandom); fl_data  = $urandom;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic evts(logic [3:0] e);
    {fl_nce_evt, ram_nce_evt, fl_sbc_evt, ram_sbc_evt} = e;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); set_buses();
    m_en = '0; m_flag = '0;
    for (int i = 0; i < 6; i++) m_cap[i] = '0;
    repeat (3) @(posedge clk);
    #1; verify_all("R1 reset");
    rst_n = 1;

    // R3 R4: events with everything disabled set nothing
    set_buses(); evts(4'hF); step("R3 R4 disabled");
    // R3: only RAM single-bit enabled
    wr(3'd0, 32'hFFFF_FFF1); step("R10 ctrl write");
    set_buses(); evts(4'b1110); step("R3 other kinds masked");
    set_buses(); evts(4'b0001); step("R3 ram sbc enabled");
    // R2: writing zeros leaves flags, then clear with 1
    wr(3'd1, 32'hFFFF_FF33); step("R2 write zero bits");
    wr(3'd1, 32'h0000_0004); step("R2 w1c ram sbc");
    chk("R8 irq falls after clear", {31'd0, irq}, 32'd0);
    // R6: all four at once with all enabled
    wr(3'd0, 32'hF); step("R4 enable all");
    set_buses(); evts(4'hF); step("R6 ram sbc wins");
    set_buses(); evts(4'b1110); step("R6 flash sbc wins");
    set_buses(); evts(4'b1100); step("R6 ram nce wins");
    set_buses(); evts(4'b1000); step("R4 flash nce");
    // R7: event collides with its clear
    set_buses(); evts(4'b0010); wr(3'd1, 32'h8C); step("R7 set beats clear");
    // R8: drop enables, irq falls while flags remain
    wr(3'd0, 32'h0); step("R8 enables off");
    wr(3'd1, 32'hCC); step("R2 clear all");
    // R9: no capture change with events disabled
    set_buses(); evts(4'hF); step("R9 no record");

    for (int n = 0; n < 400; n++) begin
      set_buses();
      evts(4'($urandom) & 4'($urandom));
      case ($urandom % 8)
        0: wr(3'd0, $urandom);
        1, 2: wr(3'd1, $urandom);
        3: wr(3'($urandom), $urandom);
        default: ;
      endcase
      step("R5 R6 random");
    end
    finish_run();
  end
endmodule